// File: doc/BRIEF.md
# Dual-Axis High-Pass Stage with Self-Test Controls

This block post-processes a single sample stream that carries X-axis and Y-axis readings in turn. Each input word is a signed 16-bit sample with an axis tag and a valid strobe. The block can negate Y-axis samples while self-test is running. It runs a first-order high-pass filter with a separate stored state for each axis. It returns one result word per accepted sample, tagged with its axis and with the self-test enable that was in force.

Four control bits come from the device control register: filter bypass, Y inversion, self-test direction and self-test enable. Setting either bypass or self-test enable takes the filter out of the path and holds both stored states where they are. A synchronous clear input zeroes both filter states. The self-test direction is passed on, one cycle later, to the actuator that drives self-test.

Top module: `dual_axis_hpf`

## Requirements
- R1: While `rst_n` is low, and on the first sample edge after it, every output is 0 and both filter states are 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. Each result carries the `in_axis` tag of its sample, where 0 means X and 1 means Y.
- R3: When a sample is accepted with `ctl_hpf_bypass`=1, `out_data` equals the sample after the inversion stage, and neither filter state changes.
- R4: When a sample is accepted with `ctl_st_en`=1, the filter is bypassed and both filter states stay frozen, the same as in R3.
- R5: When `ctl_st_en`=1 and `ctl_yinv`=1, Y samples are negated before filtering, and -32768 becomes +32767. X samples are never negated.
- R6: When `ctl_st_en`=0, `ctl_yinv` has no effect on any result.
- R7: `out_st_flag` is the value of `ctl_st_en` at the time the sample was accepted.
- R8: With the filter active, the output is e = x - s[axis] and the state is updated as s[axis] <- s[axis] + (e >>> K), where K defaults to 6. The state for each axis depends only on that axis's own samples.
- R9: With the filter active, `out_data` is e clipped to the range -32768 to +32767.
- R10: `soft_clr`=1 zeroes both filter states at the next edge, and this takes priority over an update in the same cycle. The result of that cycle's sample still uses the state from before the clear.
- R11: `st_dir_out` equals `ctl_st_dir` delayed by one clock.
- R12: In a cycle with no valid sample, `out_data`, `out_axis` and `out_st_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of both filter states |
| in_valid | input | 1 | Sample strobe |
| in_axis | input | 1 | Axis tag of the sample (0 = X, 1 = Y) |
| in_data | input | 16 | Signed sample |
| ctl_hpf_bypass | input | 1 | Bypass and freeze the filter |
| ctl_yinv | input | 1 | Negate Y samples during self-test |
| ctl_st_dir | input | 1 | Self-test direction |
| ctl_st_en | input | 1 | Self-test enable; also bypasses and freezes the filter |
| out_valid | output | 1 | Result strobe |
| out_axis | output | 1 | Axis tag of the result |
| out_data | output | 16 | Signed result |
| out_st_flag | output | 1 | Self-test enable captured with the sample |
| st_dir_out | output | 1 | Direction passed to the self-test actuator |

## Verification
A corrupted filter state does not show up at once. It appears on the next active-filter sample of that axis, as an offset in `out_data` that then decays with a time constant of about 2^K samples. For this reason the bench always un-bypasses the filter after a bypass or self-test window and compares the next samples. If the two axes shared or swapped their states, the mismatch would appear within two samples of alternating X and Y. A missing freeze stays hidden until bypass ends, and it then shows as a wrong first result. A fault in the inversion or the tagging shows on the result of the very sample that caused it.

// File: rtl/dah_pkg.sv
package dah_pkg;
    typedef enum logic {
        AXIS_X = 1'b0,
        AXIS_Y = 1'b1
    } axis_e;
endpackage

// File: rtl/dah_yinv.sv
module dah_yinv #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x_in,
    input  logic          inv_en,
    output logic [DW-1:0] x_out
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    always_comb begin
        if (!inv_en)
            x_out = x_in;
        else if (x_in == MOST_NEG)
            x_out = MOST_POS;
        else
            x_out = -x_in;
    end
endmodule

// File: rtl/dah_hpf_step.sv
module dah_hpf_step #(
    parameter int DW = 16,
    parameter int SW = 18,
    parameter int K  = 6
) (
    input  logic [DW-1:0] x,
    input  logic [SW-1:0] s,
    output logic [DW-1:0] y,
    output logic [SW-1:0] s_next
);
    localparam logic signed [SW:0] EMAX = {{(SW-DW+2){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW:0] EMIN = {{(SW-DW+2){1'b1}}, {(DW-1){1'b0}}};

    logic signed [SW:0] x_ext;
    logic signed [SW:0] s_ext;
    logic signed [SW:0] e;
    logic signed [SW:0] step;

    always_comb begin
        x_ext  = {{(SW+1-DW){x[DW-1]}}, x};
        s_ext  = {s[SW-1], s};
        e      = x_ext - s_ext;
        step   = e >>> K;
        s_next = s + step[SW-1:0];
        if (e > EMAX)
            y = EMAX[DW-1:0];
        else if (e < EMIN)
            y = EMIN[DW-1:0];
        else
            y = e[DW-1:0];
    end
endmodule

// File: rtl/dual_axis_hpf.sv
module dual_axis_hpf #(
    parameter int DW = 16,
    parameter int K  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          in_valid,
    input  logic          in_axis,
    input  logic [DW-1:0] in_data,
    input  logic          ctl_hpf_bypass,
    input  logic          ctl_yinv,
    input  logic          ctl_st_dir,
    input  logic          ctl_st_en,
    output logic          out_valid,
    output logic          out_axis,
    output logic [DW-1:0] out_data,
    output logic          out_st_flag,
    output logic          st_dir_out
);
    import dah_pkg::*;

    localparam int SW    = DW + 2;
    localparam int NAXIS = 2;

    typedef struct packed {
        logic                        vld;
        axis_e                       axis;
        logic                        flag;
        logic                        dir;
        logic [DW-1:0]               data;
        logic [NAXIS-1:0][SW-1:0]    s;
    } state_t;

    state_t st_d, st_q;

    logic                          inv_en;
    logic                          bypass;
    logic [DW-1:0]                 x_sel;
    logic [NAXIS-1:0][DW-1:0]      y_ax;
    logic [NAXIS-1:0][SW-1:0]      sn_ax;

    assign inv_en = (axis_e'(in_axis) == AXIS_Y) && ctl_st_en && ctl_yinv;
    assign bypass = ctl_hpf_bypass || ctl_st_en;

    dah_yinv #(.DW(DW)) u_yinv (
        .x_in   (in_data),
        .inv_en (inv_en),
        .x_out  (x_sel)
    );

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        dah_hpf_step #(.DW(DW), .SW(SW), .K(K)) u_step (
            .x      (x_sel),
            .s      (st_q.s[a]),
            .y      (y_ax[a]),
            .s_next (sn_ax[a])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.dir = ctl_st_dir;
        if (in_valid) begin
            st_d.axis = axis_e'(in_axis);
            st_d.flag = ctl_st_en;
            if (bypass) begin
                st_d.data = x_sel;
            end else begin
                st_d.data         = y_ax[in_axis];
                st_d.s[in_axis]   = sn_ax[in_axis];
            end
        end
        if (soft_clr)
            st_d.s = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_axis    = st_q.axis;
    assign out_data    = st_q.data;
    assign out_st_flag = st_q.flag;
    assign st_dir_out  = st_q.dir;
endmodule

// File: rtl/dual_axis_hpf_chk.sv
module dual_axis_hpf_chk #(
    parameter int DW = 16,
    parameter int SW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          in_valid,
    input logic          in_axis,
    input logic [DW-1:0] in_data,
    input logic          ctl_hpf_bypass,
    input logic          ctl_yinv,
    input logic          ctl_st_dir,
    input logic          ctl_st_en,
    input logic          out_valid,
    input logic          out_axis,
    input logic [DW-1:0] out_data,
    input logic          out_st_flag,
    input logic          st_dir_out,
    input logic [SW-1:0] sx,
    input logic [SW-1:0] sy
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_axis_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_axis == $past(in_axis));
    assert_st_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_st_flag == $past(ctl_st_en));
    assert_bypass_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ctl_hpf_bypass || ctl_st_en) && !(in_axis && ctl_st_en && ctl_yinv))
        |=> out_data == $past(in_data));
    assert_state_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && (!in_valid || ctl_hpf_bypass || ctl_st_en))
        |=> ($stable(sx) && $stable(sy)));
    assert_yinv_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_axis && ctl_st_en && ctl_yinv && in_data != MOST_NEG)
        |=> DW'(out_data + $past(in_data)) == '0);
    assert_soft_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (sx == '0 && sy == '0));
    assert_st_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_dir_out == $past(ctl_st_dir));
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_axis) && $stable(out_st_flag)));
endmodule

bind dual_axis_hpf dual_axis_hpf_chk #(.DW(DW), .SW(SW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_clr       (soft_clr),
    .in_valid       (in_valid),
    .in_axis        (in_axis),
    .in_data        (in_data),
    .ctl_hpf_bypass (ctl_hpf_bypass),
    .ctl_yinv       (ctl_yinv),
    .ctl_st_dir     (ctl_st_dir),
    .ctl_st_en      (ctl_st_en),
    .out_valid      (out_valid),
    .out_axis       (out_axis),
    .out_data       (out_data),
    .out_st_flag    (out_st_flag),
    .st_dir_out     (st_dir_out),
    .sx             (st_q.s[0]),
    .sy             (st_q.s[1])
);

// File: tb/dual_axis_hpf_tb_top.sv
module dual_axis_hpf_tb_top;
    localparam int DW = 16;
    localparam int K  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_axis = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          ctl_hpf_bypass = 1'b0;
    logic          ctl_yinv = 1'b0;
    logic          ctl_st_dir = 1'b0;
    logic          ctl_st_en = 1'b0;
    logic          out_valid;
    logic          out_axis;
    logic [DW-1:0] out_data;
    logic          out_st_flag;
    logic          st_dir_out;

    int n_vec  = 0;
    int n_fail = 0;

    int m_s [2];
    int e_data = 0;
    int e_axis = 0;
    int e_flag = 0;

    always #2ns clk = ~clk;

    dual_axis_hpf #(.DW(DW), .K(K)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_clr       (soft_clr),
        .in_valid       (in_valid),
        .in_axis        (in_axis),
        .in_data        (in_data),
        .ctl_hpf_bypass (ctl_hpf_bypass),
        .ctl_yinv       (ctl_yinv),
        .ctl_st_dir     (ctl_st_dir),
        .ctl_st_en      (ctl_st_en),
        .out_valid      (out_valid),
        .out_axis       (out_axis),
        .out_data       (out_data),
        .out_st_flag    (out_st_flag),
        .st_dir_out     (st_dir_out)
    );

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int neg_sat(int v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(bit v, bit ax, int d, bit hb, bit yi, bit sd, bit se, bit clr, string tag);
        int x;
        int e;
        int ns;
        bit byp;
        @(negedge clk);
        in_valid       = v;
        in_axis        = ax;
        in_data        = DW'(d);
        ctl_hpf_bypass = hb;
        ctl_yinv       = yi;
        ctl_st_dir     = sd;
        ctl_st_en      = se;
        soft_clr       = clr;
        if (v) begin
            x   = (ax && se && yi) ? neg_sat(d) : d;
            byp = hb || se;
            if (byp) begin
                e_data = x;
            end else begin
                e      = x - m_s[ax];
                ns     = m_s[ax] + (e >>> K);
                e_data = sat16(e);
                m_s[ax] = ns;
            end
            e_axis = ax;
            e_flag = se;
        end
        if (clr) begin
            m_s[0] = 0;
            m_s[1] = 0;
        end
        @(posedge clk);
        #1ns;
        chk({tag, " valid"}, out_valid, v);
        chk({tag, " data"}, $signed(out_data), e_data);
        chk({tag, " axis"}, out_axis, e_axis);
        chk({tag, " flag"}, out_st_flag, e_flag);
        chk({tag, " dir"}, st_dir_out, sd);
    endtask

    initial begin
        #800us;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int r;
        m_s[0] = 0;
        m_s[1] = 0;
        r = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1ns;
        chk("R1 valid", out_valid, 0);
        chk("R1 data", out_data, 0);
        chk("R1 flag", out_st_flag, 0);
        chk("R1 dir", st_dir_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: first samples see zero state, then per-axis tracking
        cyc(1, 0, 1000, 0, 0, 0, 0, 0, "R8");
        cyc(1, 1, -500, 0, 0, 0, 0, 0, "R8");
        cyc(1, 0, 1000, 0, 0, 0, 0, 0, "R8");
        cyc(1, 1, -500, 0, 0, 0, 0, 0, "R8");
        // R3: bypass passes data and freezes state
        cyc(1, 0, 1234, 1, 0, 0, 0, 0, "R3");
        cyc(1, 1, -7777, 1, 0, 0, 0, 0, "R3");
        cyc(1, 0, 1000, 0, 0, 0, 0, 0, "R3 after");
        // R4 and R7: self-test bypasses, freezes and sets flag
        cyc(1, 0, 2222, 0, 0, 1, 1, 0, "R4");
        cyc(1, 1, 3333, 0, 0, 0, 1, 0, "R4");
        cyc(1, 1, -500, 0, 0, 0, 0, 0, "R4 after");
        // R5: inversion during self-test
        cyc(1, 1, -32768, 0, 1, 0, 1, 0, "R5 sat");
        cyc(1, 1, 100, 0, 1, 0, 1, 0, "R5 neg");
        cyc(1, 0, 100, 0, 1, 0, 1, 0, "R5 xkeep");
        // R6: inversion ignored without self-test
        cyc(1, 1, 4000, 0, 1, 0, 0, 0, "R6");
        cyc(1, 1, 4000, 0, 1, 0, 0, 0, "R6");
        // R12: idle cycles keep the result
        cyc(0, 1, 9999, 0, 0, 1, 1, 0, "R12");
        cyc(0, 0, -9999, 1, 1, 0, 0, 0, "R12");
        // R11: direction follows
        cyc(0, 0, 0, 0, 0, 1, 0, 0, "R11");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        // R10: clear, with and without a sample in the same cycle
        cyc(1, 0, 500, 0, 0, 0, 0, 1, "R10 same");
        cyc(1, 0, 500, 0, 0, 0, 0, 0, "R10 after");
        cyc(1, 1, 600, 0, 0, 0, 0, 0, "R10 after");
        // R9: drive state far negative, then a full-scale positive step
        for (int i = 0; i < 700; i++) cyc(1, 0, -32768, 0, 0, 0, 0, 0, "R9 ramp");
        cyc(1, 0, 32767, 0, 0, 0, 0, 0, "R9 pos");
        for (int i = 0; i < 700; i++) cyc(1, 1, 32767, 0, 0, 0, 0, 0, "R9 ramp");
        cyc(1, 1, -32768, 0, 0, 0, 0, 0, "R9 neg");

        // random mix, R2 and R8 every cycle
        for (int i = 0; i < 6000; i++) begin
            int sel;
            int d;
            sel = $urandom_range(0, 9);
            if (sel == 0) d = -32768;
            else if (sel == 1) d = 32767;
            else d = $urandom_range(0, 65535) - 32768;
            cyc($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), d,
                $urandom_range(0, 7) == 0, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
                $urandom_range(0, 99) == 0, "R2 R8 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule